// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit signed product in a single combinational pass. The multiplier operand is cut into overlapping three-bit groups. Each group becomes one radix-4 digit, so only N/2 partial-product rows are produced instead of N. Each digit is turned into a four-bit select word. That word steers a row generator, which picks zero, the multiplicand, or twice the multiplicand, with or without negation.

Negative rows are formed as the bitwise inverse plus one. The inverse is made in the row generator. The one is injected separately as a correction bit at the row's lowest column. Every row is sign-extended to the full product width. The rows and the correction vector are folded into a sum/carry pair by a chain of 3:2 full-adder compressors. A ripple adder then produces the product and drops the carry out of the top bit. The default build is 8x8 with a 16-bit result.

Top module: `booth_mult`

## Requirements
- R1: `prod_o` equals the signed product of `mcand_i` and `mplier_i`, taken modulo 2^(2N), for every operand pair.
- R2: Row i uses the digit -2·y[2i+1] + y[2i] + y[2i-1], with y[-1] read as 0, for i from 0 to N/2-1.
- R3: The encoder maps a triplet {hi,mid,lo} to the select word {s0,s1,s2,s3}, with s0 as the most significant bit, as follows:
  - 000 and 111 give 0101 (zero).
  - 001 and 010 give 1101 (+X).
  - 011 gives 0111 (+2X).
  - 100 gives 0100 (-2X).
  - 101 and 110 give 0001 (-X).
- R4: Each row, added to its correction bit, equals the digit times the multiplicand modulo 2^(N+1). The doubled selections take bit j-1 of the multiplicand into row bit j.
- R5: The correction bit of row i is 1 exactly when that row's digit is negative, and it enters the sum at column 2i.
- R6: Extreme operands give the exact product with no overflow artefact. The extremes include the most negative value times itself (16384 for N=8) and the most negative value times the most positive.
- R7: A zero in either operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | N | Signed multiplicand |
| mplier_i | input | N | Signed multiplier, recoded into radix-4 digits |
| prod_o | output | 2N | Signed product |

## Verification
Some properties are checked every time the inputs change:
- every select word is one of the five legal codes;
- each row together with its correction bit equals the recoded digit times the multiplicand;
- each correction bit matches the sign of its digit;
- the final product matches a reference multiplication.

Some things only the bench scenarios show:
- the exact select word produced for each of the eight triplets;
- the behaviour at the operand extremes and at zero;
- agreement over all 65536 operand pairs of the default width.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Select word driven by one recoding cell; s0 is the most significant bit.
    typedef struct packed {
        logic s0;
        logic s1;
        logic s2;
        logic s3;
    } bsel_t;

    localparam bsel_t SEL_ZERO  = 4'b0101;
    localparam bsel_t SEL_POS1  = 4'b1101;
    localparam bsel_t SEL_POS2  = 4'b0111;
    localparam bsel_t SEL_NEG2  = 4'b0100;
    localparam bsel_t SEL_NEG1  = 4'b0001;

    // Single multiple selected (magnitude 1).
    function automatic logic sel_one(bsel_t s);
        return s.s0 | ~s.s1;
    endfunction

    // Doubled multiple selected (magnitude 2).
    function automatic logic sel_two(bsel_t s);
        return s.s2 | ~s.s3;
    endfunction

    // Row must be negated.
    function automatic logic sel_neg(bsel_t s);
        return ~(s.s1 & s.s3);
    endfunction

endpackage

// File: rtl/booth_enc.sv
module booth_enc
    import booth_pkg::*;
(
    input  logic [2:0] trip_i,
    output bsel_t      sel_o
);

    bsel_t sel_d;

    always_comb begin
        case (trip_i)
            3'b001, 3'b010: sel_d = SEL_POS1;
            3'b011:         sel_d = SEL_POS2;
            3'b100:         sel_d = SEL_NEG2;
            3'b101, 3'b110: sel_d = SEL_NEG1;
            default:        sel_d = SEL_ZERO;
        endcase
    end

    assign sel_o = sel_d;

endmodule

// File: rtl/booth_ppg.sv
module booth_ppg
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] x_i,
    input  bsel_t        sel_i,
    output logic [N:0]   row_o,
    output logic         neg_o
);

    localparam int RW = N + 1;

    logic       one_d;
    logic       two_d;
    logic       neg_d;
    logic [N+1:0] xe;   // xe[j+1] holds x[j]; xe[0] is the zero below bit 0

    assign one_d = sel_one(sel_i);
    assign two_d = sel_two(sel_i);
    assign neg_d = sel_neg(sel_i);
    assign xe    = {x_i[N-1], x_i, 1'b0};

    for (genvar j = 0; j < RW; j++) begin : g_cell
        assign row_o[j] = ((one_d & xe[j+1]) | (two_d & xe[j])) ^ neg_d;
    end

    assign neg_o = neg_d;

endmodule

// File: rtl/booth_csa.sv
module booth_csa #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);

    for (genvar j = 0; j < W; j++) begin : g_fa
        assign sum_o[j] = a_i[j] ^ b_i[j] ^ c_i[j];
        if (j < W - 1) begin : g_maj
            assign cry_o[j+1] = (a_i[j] & b_i[j]) | (a_i[j] & c_i[j]) | (b_i[j] & c_i[j]);
        end
    end

    assign cry_o[0] = 1'b0;

endmodule

// File: rtl/booth_fpa.sv
module booth_fpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] c;

    assign c[0] = 1'b0;

    for (genvar j = 0; j < W; j++) begin : g_bit
        assign sum_o[j] = a_i[j] ^ b_i[j] ^ c[j];
        if (j < W - 1) begin : g_cy
            assign c[j+1] = (a_i[j] & b_i[j]) | (c[j] & (a_i[j] ^ b_i[j]));
        end
    end

endmodule

// File: rtl/booth_mult.sv
module booth_mult
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic [2*N-1:0] prod_o
);

    localparam int ROWS   = N / 2;
    localparam int W      = 2 * N;
    localparam int OPS    = ROWS + 1;
    localparam int STAGES = OPS - 2;

    logic [N:0]    ypad;
    bsel_t         sel [ROWS];
    logic [N:0]    row [ROWS];
    logic [ROWS-1:0] neg;
    logic [W-1:0]  opnd_d [OPS];
    logic [W-1:0]  ps [STAGES+1];
    logic [W-1:0]  pc [STAGES+1];

    assign ypad = {mplier_i, 1'b0};

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        booth_enc u_enc (
            .trip_i (ypad[2*i+2 -: 3]),
            .sel_o  (sel[i])
        );
        booth_ppg #(.N(N)) u_ppg (
            .x_i   (mcand_i),
            .sel_i (sel[i]),
            .row_o (row[i]),
            .neg_o (neg[i])
        );
    end

    // Sign-extend and place each row; gather correction bits in one vector.
    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            opnd_d[i] = {{(W-N-1){row[i][N]}}, row[i]} << (2 * i);
        end
        opnd_d[ROWS] = '0;
        for (int i = 0; i < ROWS; i++) begin
            opnd_d[ROWS][2*i] = neg[i];
        end
    end

    assign ps[0] = opnd_d[0];
    assign pc[0] = opnd_d[1];

    for (genvar k = 0; k < STAGES; k++) begin : g_csa
        booth_csa #(.W(W)) u_csa (
            .a_i   (ps[k]),
            .b_i   (pc[k]),
            .c_i   (opnd_d[k+2]),
            .sum_o (ps[k+1]),
            .cry_o (pc[k+1])
        );
    end

    booth_fpa #(.W(W)) u_fpa (
        .a_i   (ps[STAGES]),
        .b_i   (pc[STAGES]),
        .sum_o (prod_o)
    );

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input logic [N-1:0]     mcand,
    input logic [N-1:0]     mplier,
    input logic [2*N-1:0]   prod,
    input bsel_t            sel [N/2],
    input logic [N:0]       row [N/2],
    input logic [N/2-1:0]   neg
);

    localparam int ROWS = N / 2;
    localparam int RMSK = (1 << (N + 1)) - 1;

    function automatic int digit_of(logic [N-1:0] y, int i);
        logic [N:0] yp;
        yp = {y, 1'b0};
        return -2 * int'(yp[2*i+2]) + int'(yp[2*i+1]) + int'(yp[2*i]);
    endfunction

    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            // R3
            enc_code_chk: assert (sel[i] inside {SEL_ZERO, SEL_POS1, SEL_POS2, SEL_NEG2, SEL_NEG1})
                else $error("illegal select word in row %0d", i);
            // R4
            row_value_chk: assert ((((int'(row[i]) + int'(neg[i]))
                                     - digit_of(mplier, i) * int'($signed(mcand))) & RMSK) == 0)
                else $error("row %0d value mismatch", i);
            // R5
            neg_flag_chk: assert (neg[i] == (digit_of(mplier, i) < 0))
                else $error("row %0d correction bit mismatch", i);
        end
        // R1
        prod_ref_chk: assert (prod == (2*N)'(int'($signed(mcand)) * int'($signed(mplier))))
            else $error("product mismatch");
    end

endmodule

bind booth_mult booth_mult_chk #(.N(N)) u_chk (
    .mcand  (mcand_i),
    .mplier (mplier_i),
    .prod   (prod_o),
    .sel    (sel),
    .row    (row),
    .neg    (neg)
);

// File: tb/sim_booth_mult.sv
module sim_booth_mult;
    import booth_pkg::*;

    localparam int N = 8;
    localparam int WD_CYCLES = 150000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   x = '0;
    logic [N-1:0]   y = '0;
    logic [2*N-1:0] p;
    logic [2:0]     trip = '0;
    bsel_t          sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    booth_mult #(.N(N)) u0 (
        .mcand_i  (x),
        .mplier_i (y),
        .prod_o   (p)
    );

    booth_enc u1 (
        .trip_i (trip),
        .sel_o  (sel)
    );

    task automatic check(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] ref_prod(logic [N-1:0] a, logic [N-1:0] b);
        return (2*N)'(int'($signed(a)) * int'($signed(b)));
    endfunction

    task automatic apply(logic [N-1:0] a, logic [N-1:0] b);
        @(posedge clk);
        x <= a;
        y <= b;
        @(negedge clk);
    endtask

    // R7: during reset the operands are held at zero
    task automatic t_reset();
        @(negedge clk);
        check("R7 reset", p, '0);
    endtask

    // R3: every triplet code against the select-word table
    task automatic t_encoder();
        logic [3:0] exp;
        for (int t = 0; t < 8; t++) begin
            case (t)
                1, 2:    exp = 4'b1101;
                3:       exp = 4'b0111;
                4:       exp = 4'b0100;
                5, 6:    exp = 4'b0001;
                default: exp = 4'b0101;
            endcase
            @(posedge clk);
            trip <= 3'(t);
            @(negedge clk);
            check("R3 encoder", {12'h0, sel}, {12'h0, exp});
        end
    endtask

    // R6 / R2 / R4: extremes and single-digit multipliers
    task automatic t_corners();
        apply(8'h80, 8'h80);
        check("R6 min*min", p, 16'h4000);
        apply(8'h80, 8'h7F);
        check("R6 min*max", p, 16'hC080);
        apply(8'h7F, 8'h7F);
        check("R6 max*max", p, 16'h3F01);
        apply(8'hFF, 8'hFF);
        check("R6 -1*-1", p, 16'h0001);
        apply(8'h55, 8'h02);
        check("R4 doubled row", p, ref_prod(8'h55, 8'h02));
        apply(8'h33, 8'h80);
        check("R2 top digit -2", p, ref_prod(8'h33, 8'h80));
        apply(8'h5A, 8'hAA);
        check("R5 negative rows", p, ref_prod(8'h5A, 8'hAA));
        apply(8'h81, 8'h01);
        check("R2 y(-1)=0", p, 16'hFF81);
    endtask

    // R7: zero on either side
    task automatic t_zero();
        apply(8'h00, 8'h9C);
        check("R7 zero mcand", p, '0);
        apply(8'h9C, 8'h00);
        check("R7 zero mplier", p, '0);
    endtask

    // R1: every operand pair
    task automatic t_exhaustive();
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                apply(8'(a), 8'(b));
                check("R1 exhaustive", p, ref_prod(8'(a), 8'(b)));
            end
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        t_reset();
        rst <= 1'b0;
        t_encoder();
        t_corners();
        t_zero();
        t_exhaustive();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule